// File: doc/BRIEF.md
# Doorbell and Software-Trigger Unit

This block keeps a 32-bit inbound doorbell word for each CPU of a small cluster and raises two summary interrupt lines per CPU from it. Doorbells 0 to 7 form the inter-processor group. Doorbells 16 to 31 form the message group. Doorbells 8 to 15 can be set and read back but belong to neither group.

Any bus master posts a doorbell by writing one trigger word into the shared window. The low field of the word names the doorbell. A four-bit field above it names every CPU that receives the doorbell. A message-signalled write lands in this same trigger word. Each CPU has its own window, selected by a CPU-index sideband. That window holds a cause register, which is cleared by writing zeros, and a mask register, which enables doorbells.

Bus reads are registered, so read data appears one cycle after the read strobe. A trigger write passes through one pipeline register before it reaches the cause bits.

Top module: `doorbell_unit`

## Requirements
- R1: After reset, every cause register and every mask register reads 0, and all summary outputs are low.
- R2: A write to shared offset 0x4 carries the doorbell number in bits [4:0] and the target bitmap in bits [11:8], where bit 8+c selects CPU c. The named cause bit is set in each selected CPU, and unselected CPUs are left unchanged. An empty bitmap changes nothing.
- R3: The trigger value 0xF00 | (k+16) sets doorbell 16+k in all four CPUs.
- R4: A read of per-CPU offset 0x8 returns the raw pending bits of that CPU, whatever the mask holds.
- R5: A write to per-CPU offset 0x8 clears each cause bit written as 0 and keeps each bit written as 1. Writing 0 clears every pending doorbell.
- R6: When a trigger reaches a cause bit in the same cycle that a cause write clears it, the bit ends up set.
- R7: Per-CPU offset 0xC is a read/write mask register, where 1 enables a doorbell. The inter-processor summary is high when any bit in positions 0 to 7 is both pending and enabled. The message summary is high when any bit in positions 16 to 31 is both pending and enabled.
- R8: Doorbells 8 to 15 are latched in the cause register but never raise either summary, even when they are enabled.
- R9: Writes to one CPU's window (chosen by the CPU-index sideband) leave the registers of every other CPU unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data is valid on the next cycle |
| bus_shared | input | 1 | 1 selects the shared window, 0 selects a per-CPU window |
| bus_addr | input | 8 | Byte offset within the selected window |
| bus_cpu | input | 2 | CPU index for per-CPU window accesses |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ipi_irq | output | 4 | Inter-processor summary, one bit per CPU |
| msg_irq | output | 4 | Message summary, one bit per CPU |

## Verification
The assertions assume a single bus port. At most one register is written per cycle, so a collision between a trigger and a clear can only come from a trigger that is still in the pipeline when a cause write arrives. The assertions also assume that the CPU index is in range, and that reset is held for at least one clock edge. The stimulus drives one access per cycle on the falling edge and always uses valid CPU indices. After every trigger it waits one idle cycle before reading, except in the collision test, where a cause write follows the trigger directly to reach the same edge on purpose.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
    localparam int DB_W = 32;
    localparam int NUM_W = $clog2(DB_W);
    localparam logic [DB_W-1:0] IPI_GRP = 32'h0000_00FF;
    localparam logic [DB_W-1:0] MSG_GRP = 32'hFFFF_0000;
    localparam logic [7:0] OFF_TRIG  = 8'h04;
    localparam logic [7:0] OFF_CAUSE = 8'h08;
    localparam logic [7:0] OFF_MASK  = 8'h0C;
endpackage

// File: rtl/doorbell_trig_dec.sv
module doorbell_trig_dec
    import doorbell_pkg::*;
#(
    parameter int NCPU    = 4,
    parameter int TGT_LSB = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       trig_wr,
    input  logic [DB_W-1:0]            wdata,
    output logic [NCPU-1:0][DB_W-1:0]  set_o
);
    typedef struct packed {
        logic [NCPU-1:0][DB_W-1:0] set;
    } dec_state_t;

    dec_state_t st_d, st_q;

    always_comb begin
        st_d = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (trig_wr && wdata[TGT_LSB + c])
                st_d.set[c] = DB_W'(1) << wdata[NUM_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign set_o = st_q.set;
endmodule

// File: rtl/doorbell_cpu_bank.sv
module doorbell_cpu_bank
    import doorbell_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DB_W-1:0] set_i,
    input  logic            cause_wr_i,
    input  logic            mask_wr_i,
    input  logic [DB_W-1:0] wdata_i,
    output logic [DB_W-1:0] cause_o,
    output logic [DB_W-1:0] mask_o,
    output logic            ipi_o,
    output logic            msg_o
);
    typedef struct packed {
        logic [DB_W-1:0] cause;
        logic [DB_W-1:0] mask;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [DB_W-1:0] live;

    always_comb begin
        st_d = st_q;
        if (cause_wr_i) st_d.cause = st_q.cause & wdata_i;
        st_d.cause = st_d.cause | set_i;
        if (mask_wr_i) st_d.mask = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live    = st_q.cause & st_q.mask;
    assign ipi_o   = |(live & IPI_GRP);
    assign msg_o   = |(live & MSG_GRP);
    assign cause_o = st_q.cause;
    assign mask_o  = st_q.mask;

    // R2
    set_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_i));
    // R6
    trig_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((cause_o & $past(set_i)) == $past(set_i)));
    // R5
    clr_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_wr_i && set_i == '0) |=> (cause_o == ($past(cause_o) & $past(wdata_i))));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cause_wr_i && set_i == '0) |=> $stable(cause_o));
    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr_i |=> $stable(mask_o));
    // R8
    gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_o & mask_o & ~DB_W'(16'hFF00)) == '0) |-> !(ipi_o || msg_o));
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
    import doorbell_pkg::*;
#(
    parameter int NCPU    = 4,
    parameter int TGT_LSB = 8,
    localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_shared,
    input  logic [7:0]       bus_addr,
    input  logic [CPU_W-1:0] bus_cpu,
    input  logic [DB_W-1:0]  bus_wdata,
    output logic [DB_W-1:0]  bus_rdata,
    output logic [NCPU-1:0]  ipi_irq,
    output logic [NCPU-1:0]  msg_irq
);
    typedef struct packed {
        logic [DB_W-1:0] rdata;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic trig_wr;
    logic [NCPU-1:0][DB_W-1:0] set_v, cause_v, mask_v;
    logic [NCPU-1:0] cause_wr, mask_wr;

    assign trig_wr = bus_wr && bus_shared && (bus_addr == OFF_TRIG);

    doorbell_trig_dec #(.NCPU(NCPU), .TGT_LSB(TGT_LSB)) u_dec (
        .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr),
        .wdata(bus_wdata), .set_o(set_v)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        assign cause_wr[c] = bus_wr && !bus_shared && (bus_addr == OFF_CAUSE)
                             && (bus_cpu == CPU_W'(c));
        assign mask_wr[c]  = bus_wr && !bus_shared && (bus_addr == OFF_MASK)
                             && (bus_cpu == CPU_W'(c));
        doorbell_cpu_bank u_bank (
            .clk(clk), .rst_n(rst_n), .set_i(set_v[c]),
            .cause_wr_i(cause_wr[c]), .mask_wr_i(mask_wr[c]),
            .wdata_i(bus_wdata), .cause_o(cause_v[c]), .mask_o(mask_v[c]),
            .ipi_o(ipi_irq[c]), .msg_o(msg_irq[c])
        );
    end

    always_comb begin
        st_d = st_q;
        if (bus_rd) begin
            st_d.rdata = '0;
            if (!bus_shared) begin
                if (bus_addr == OFF_CAUSE)     st_d.rdata = cause_v[bus_cpu];
                else if (bus_addr == OFF_MASK) st_d.rdata = mask_v[bus_cpu];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    // R9
    one_bank_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_wr | mask_wr));
endmodule

// File: tb/sim_doorbell_unit.sv
module sim_doorbell_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 0, bus_rd = 0, bus_shared = 0;
    logic [7:0] bus_addr = '0;
    logic [1:0] bus_cpu = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0] ipi_irq, msg_irq;

    int n_chk = 0, n_bad = 0;
    logic rd_d1 = 1'b0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    doorbell_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_shared(bus_shared), .bus_addr(bus_addr), .bus_cpu(bus_cpu),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ipi_irq(ipi_irq), .msg_irq(msg_irq)
    );

    always @(posedge clk) rd_d1 <= bus_rd;

    always @(negedge clk) begin
        if (rd_d1 && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (bus_rdata !== e) begin
                n_bad++;
                $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic sh, input logic [7:0] a, input logic [1:0] c,
                      input logic [31:0] d);
        bus_wr = 1; bus_shared = sh; bus_addr = a; bus_cpu = c; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic trig(input logic [31:0] d);
        wr(1'b1, 8'h04, 2'd0, d);
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] c, input logic [7:0] a,
                      input logic [31:0] e, input string t);
        bus_rd = 1; bus_shared = 0; bus_addr = a; bus_cpu = c;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic sum_chk(input int c, input logic ei, input logic em, input string t);
        n_chk++;
        if (ipi_irq[c] !== ei || msg_irq[c] !== em) begin
            n_bad++;
            $display("FAIL %s: cpu%0d ipi/msg actual %b%b expected %b%b",
                     t, c, ipi_irq[c], msg_irq[c], ei, em);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        for (int c = 0; c < 4; c++) begin
            rd(2'(c), 8'h08, 32'h0, "R1 cause");
            rd(2'(c), 8'h0C, 32'h0, "R1 mask");
            sum_chk(c, 0, 0, "R1 summary");
        end
        // R2: doorbell 2 to cpu0 and cpu2
        trig(32'h0000_0502); idle();
        rd(0, 8'h08, 32'h4, "R2 cpu0");
        rd(1, 8'h08, 32'h0, "R2 cpu1 untouched");
        rd(2, 8'h08, 32'h4, "R2 cpu2");
        sum_chk(0, 0, 0, "R7 masked");
        wr(0, 8'h0C, 0, 32'h0000_00FF);
        sum_chk(0, 1, 0, "R7 ipi on");
        sum_chk(2, 0, 0, "R7 cpu2 still masked");
        rd(0, 8'h0C, 32'hFF, "R7 mask readback");
        // R3: message write k=5
        trig(32'h0000_0F00 | 32'd21); idle();
        rd(3, 8'h08, 32'h0020_0000, "R3 cpu3");
        rd(0, 8'h08, 32'h0020_0004, "R3 cpu0");
        sum_chk(0, 1, 0, "R7 msg masked");
        wr(0, 8'h0C, 0, 32'hFFFF_00FF);
        sum_chk(0, 1, 1, "R7 msg on");
        rd(1, 8'h08, 32'h0020_0000, "R4 raw despite mask");
        // R5
        wr(0, 8'h08, 0, ~32'h0020_0000);
        rd(0, 8'h08, 32'h4, "R5 partial clear");
        sum_chk(0, 1, 0, "R5 msg dropped");
        wr(0, 8'h08, 0, 32'h0);
        rd(0, 8'h08, 32'h0, "R5 clear all");
        sum_chk(0, 0, 0, "R5 ipi dropped");
        // R8
        wr(0, 8'h08, 1, 32'h0);
        wr(0, 8'h0C, 1, 32'hFFFF_FFFF);
        trig(32'h0000_020C); idle();
        rd(1, 8'h08, 32'h0000_1000, "R8 latched");
        sum_chk(1, 0, 0, "R8 no summary");
        // R6: trigger then clear on the same edge
        trig(32'h0000_0203);
        wr(0, 8'h08, 1, 32'h0);
        idle();
        rd(1, 8'h08, 32'h8, "R6 trigger wins");
        sum_chk(1, 1, 0, "R6 ipi");
        // R2 empty bitmap
        trig(32'h0000_0005); idle();
        rd(3, 8'h08, 32'h0020_0000, "R2 empty bitmap");
        // R9
        wr(0, 8'h0C, 2, 32'h1234_5678);
        rd(3, 8'h0C, 32'h0, "R9 cpu3 mask");
        rd(2, 8'h0C, 32'h1234_5678, "R9 cpu2 mask");
        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule